// File: doc/BRIEF.md
# Card Power Control Sequencer

This block owns the power state of a memory-card interface. A two-bit mode field, written through a small register port, picks one of three states: power-cycle, power-off or power-on. In power-cycle the card clock, the command line and every data line are pulled low. This keeps the card from drawing supply current through its signal pins. In power-off the host side is idle and all card signals are held high.

When the block enters power-on it releases the card clock at once. It keeps the command and data lines held high for a fixed number of card-clock periods, so the card sees its start-up clocks before any traffic. Card-clock periods arrive as a one-cycle tick from the clock divider, which sits outside this block. When the count is reached, a ready output tells the command and data engines they may drive the lines.

Software is expected to step through power-cycle, then power-off, then power-on, leaving about a millisecond between the last two. The register also holds three side bits: a direction-polarity bit, a voltage-switch request bit and a voltage-switch enable bit. The block stores them and brings them out. It does not sequence them.

Top module: `card_power_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads back 0 (mode 00, all side bits 0), ready is 0 and every card signal is forced high.
- R2: A write with wr_en high stores wr_data[4:0] at the next rising clock edge, and rd_data returns it from then on. Bits [1:0] are the mode, bit 2 is the voltage-switch request, bit 3 is the voltage-switch enable and bit 4 is the direction polarity.
- R3: With mode 10 (power-cycle), the clock, the command line and all data lines are forced (force=1) to level 0.
- R4: With mode 00 (power-off), the clock, the command line and all data lines are forced to level 1.
- R5: Mode 01 is reserved and drives the pads exactly as power-off, with ready 0.
- R6: With mode 11 (power-on), the clock is released (force=0, level=0). Until LOCK_CLKS (74) card-clock ticks have been counted in power-on, the command and data lines stay forced high and ready stays 0.
- R7: On the rising edge that captures the 74th tick in power-on, ready becomes 1 and the command and data lines are released (force=0, level=0).
- R8: Writing mode 11 again while already in power-on neither restarts the count nor drops ready.
- R9: A write that leaves power-on drops ready and restores the forced levels at the same edge that changes the mode. Re-entering power-on starts a fresh count from zero.
- R10: The dir_pol, vswitch and vswitch_en outputs follow the stored bits 4, 2 and 3 in every mode.
- R11: Ticks received outside power-on add nothing to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| card_tick | input | 1 | One-cycle pulse per card-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Register write value |
| rd_data | output | 5 | Register read value |
| ck_force | output | 1 | Card clock pad overridden by this block |
| ck_level | output | 1 | Card clock override level |
| cmd_force | output | 1 | Command pad overridden |
| cmd_level | output | 1 | Command override level |
| dat_force | output | 8 | Data pads overridden, one bit per lane |
| dat_level | output | 8 | Data override levels |
| ready | output | 1 | Command and data engines may run |
| dir_pol | output | 1 | Stored direction-polarity bit |
| vswitch | output | 1 | Stored voltage-switch request bit |
| vswitch_en | output | 1 | Stored voltage-switch enable bit |

## Verification
Every result appears one rising edge after its cause. A write shows on rd_data, the side bits and the pad controls after the edge that captures it. Ready rises after the edge that captures the 74th tick and falls after the edge that captures a write leaving power-on. Ticks in the cycle after a mode write already count. The bench keeps a reference model that it updates at each rising edge from the inputs it drove. It compares every output against that model at the following falling edge, so each check lands exactly one edge after its stimulus. Reset release passes through two synchronizer flops, and the bench waits them out before its first check.

// File: rtl/cpwr_pkg.sv
package cpwr_pkg;

  typedef enum logic [1:0] {
    PWR_OFF   = 2'b00,
    PWR_RSVD  = 2'b01,
    PWR_CYCLE = 2'b10,
    PWR_ON    = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic      dir_pol;
    logic      vsw_en;
    logic      vsw;
    pwr_mode_e mode;
  } pwr_ctrl_t;

  localparam int CTRL_W = $bits(pwr_ctrl_t);

  typedef enum logic [1:0] {
    DRV_LOW     = 2'b00,
    DRV_HIGH    = 2'b01,
    DRV_RELEASE = 2'b10
  } drive_e;

endpackage

// File: rtl/cpwr_rst_sync.sv
module cpwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cpwr_ctrl_reg.sv
module cpwr_ctrl_reg
  import cpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output pwr_ctrl_t         ctrl_q
);

  pwr_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = pwr_ctrl_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == $past(wr_data)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/cpwr_lockout.sv
module cpwr_lockout #(
  parameter int LOCK_CLKS = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_on,
  input  logic tick,
  output logic ready
);

  localparam int CW = $clog2(LOCK_CLKS + 1);
  localparam logic [CW-1:0] LOCK_VAL = CW'(LOCK_CLKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = tick && (cnt_q != LOCK_VAL);
    if (!power_on)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = power_on && (cnt_q == LOCK_VAL);

  // R6
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOCK_VAL);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (power_on && $past(power_on)) |->
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on |=> (cnt_q == '0));

  // R9
  entry_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (power_on && !$past(power_on)) |-> !ready);

endmodule

// File: rtl/cpwr_pad_drive.sv
module cpwr_pad_drive
  import cpwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  pwr_mode_e         mode,
  input  logic              ready,
  output logic              ck_force,
  output logic              ck_level,
  output logic              cmd_force,
  output logic              cmd_level,
  output logic [DATA_W-1:0] dat_force,
  output logic [DATA_W-1:0] dat_level
);

  drive_e ck_drv;
  drive_e line_drv;
  logic   line_force;
  logic   line_level;

  always_comb begin
    unique case (mode)
      PWR_CYCLE: begin
        ck_drv   = DRV_LOW;
        line_drv = DRV_LOW;
      end
      PWR_ON: begin
        ck_drv   = DRV_RELEASE;
        line_drv = ready ? DRV_RELEASE : DRV_HIGH;
      end
      default: begin
        ck_drv   = DRV_HIGH;
        line_drv = DRV_HIGH;
      end
    endcase
  end

  assign ck_force   = (ck_drv != DRV_RELEASE);
  assign ck_level   = (ck_drv == DRV_HIGH);
  assign line_force = (line_drv != DRV_RELEASE);
  assign line_level = (line_drv == DRV_HIGH);
  assign cmd_force  = line_force;
  assign cmd_level  = line_level;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign dat_force[i] = line_force;
    assign dat_level[i] = line_level;
  end

endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import cpwr_pkg::*;
#(
  parameter int LOCK_CLKS = 74,
  parameter int DATA_W    = 8,
  parameter int SYNC_FF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_tick,
  input  logic              wr_en,
  input  logic [4:0]        wr_data,
  output logic [4:0]        rd_data,
  output logic              ck_force,
  output logic              ck_level,
  output logic              cmd_force,
  output logic              cmd_level,
  output logic [DATA_W-1:0] dat_force,
  output logic [DATA_W-1:0] dat_level,
  output logic              ready,
  output logic              dir_pol,
  output logic              vswitch,
  output logic              vswitch_en
);

  logic      srst_n;
  pwr_ctrl_t ctrl_q;
  logic      power_on;

  cpwr_rst_sync #(.STAGES(SYNC_FF)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cpwr_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  assign power_on = (ctrl_q.mode == PWR_ON);

  cpwr_lockout #(.LOCK_CLKS(LOCK_CLKS)) u_lock (
    .clk      (clk),
    .rst_n    (srst_n),
    .power_on (power_on),
    .tick     (card_tick),
    .ready    (ready)
  );

  cpwr_pad_drive #(.DATA_W(DATA_W)) u_pad (
    .mode      (ctrl_q.mode),
    .ready     (ready),
    .ck_force  (ck_force),
    .ck_level  (ck_level),
    .cmd_force (cmd_force),
    .cmd_level (cmd_level),
    .dat_force (dat_force),
    .dat_level (dat_level)
  );

  assign rd_data    = ctrl_q;
  assign dir_pol    = ctrl_q.dir_pol;
  assign vswitch    = ctrl_q.vsw;
  assign vswitch_en = ctrl_q.vsw_en;

  // R7
  ready_release_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ready |-> (!cmd_force && !ck_force && (dat_force == '0)));

  // R3
  cycle_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data[1:0] == 2'b10) |-> (ck_force && !ck_level && !cmd_level && (dat_level == '0)));

  // R9
  exit_drop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data[1:0] != 2'b11) |-> (!ready && cmd_force));

endmodule

// File: tb/card_power_seq_test.sv
module card_power_seq_test;

  localparam int LOCK = 74;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       card_tick;
  logic       wr_en;
  logic [4:0] wr_data;
  logic [4:0] rd_data;
  logic       ck_force, ck_level, cmd_force, cmd_level;
  logic [7:0] dat_force, dat_level;
  logic       ready, dir_pol, vswitch, vswitch_en;

  always #4 clk = ~clk;

  card_power_seq uut (
    .clk(clk), .rst_n(rst_n), .card_tick(card_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ck_force(ck_force),
    .ck_level(ck_level), .cmd_force(cmd_force), .cmd_level(cmd_level),
    .dat_force(dat_force), .dat_level(dat_level), .ready(ready),
    .dir_pol(dir_pol), .vswitch(vswitch), .vswitch_en(vswitch_en)
  );

  int   errs = 0;
  int   checks = 0;
  bit   done = 0;
  logic [4:0] m_reg;
  int   m_cnt;

  function automatic logic [28:0] expect_out(logic [4:0] r, int c);
    logic rdy, ckf, ckl, lnf, lnl;
    rdy = (r[1:0] == 2'b11) && (c == LOCK);
    case (r[1:0])
      2'b10:   begin ckf = 1; ckl = 0; lnf = 1; lnl = 0; end
      2'b11:   begin ckf = 0; ckl = 0; lnf = !rdy; lnl = !rdy; end
      default: begin ckf = 1; ckl = 1; lnf = 1; lnl = 1; end
    endcase
    return {ckf, ckl, lnf, lnl, {8{lnf}}, {8{lnl}}, rdy, r[2], r[3], r[4], r};
  endfunction

  function automatic logic [28:0] got_out();
    return {ck_force, ck_level, cmd_force, cmd_level, dat_force, dat_level,
            ready, vswitch, vswitch_en, dir_pol, rd_data};
  endfunction

  task automatic check(string tag);
    logic [28:0] e, g;
    e = expect_out(m_reg, m_cnt);
    g = got_out();
    checks++;
    if (g !== e) begin
      errs++;
      $display("FAIL %s: got=%h expected=%h", tag, g, e);
    end
  endtask

  task automatic step(bit we, logic [4:0] wd, bit tk);
    wr_en = we; wr_data = wd; card_tick = tk;
    @(posedge clk);
    if (m_reg[1:0] != 2'b11) m_cnt = 0;
    else if (tk && m_cnt < LOCK) m_cnt++;
    if (we) m_reg = wd;
    @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; wr_en = 0; wr_data = 0; card_tick = 0;
    m_reg = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    apply_reset();
    check("R1 after release");

    step(1, 5'b00010, 0); check("R3 power-cycle pads");
    step(0, 0, 1);        check("R3 hold cycle");
    step(1, 5'b00000, 0); check("R4 power-off pads");
    step(1, 5'b00001, 1); check("R5 reserved as off");
    for (int i = 0; i < 20; i++) begin step(0, 0, 1); check("R5 R11 reserved ticks"); end

    step(1, 5'b10111, 0); check("R6 entry R10 side bits");
    for (int i = 0; i < LOCK - 1; i++) begin
      step(0, 0, 1); check("R6 lockout");
      if (i % 10 == 0) begin step(0, 0, 0); check("R6 idle cycle"); end
    end
    step(0, 0, 1); check("R7 ready after 74th tick");
    step(0, 0, 1); check("R7 ready holds");

    step(1, 5'b01011, 1); check("R8 rewrite keeps ready R10");
    step(0, 0, 0);        check("R8 still ready");

    step(1, 5'b00010, 1); check("R9 exit drops ready");
    step(1, 5'b00011, 1); check("R9 re-entry not ready");
    for (int i = 0; i < LOCK - 1; i++) begin step(0, 0, 1); check("R9 fresh count"); end
    step(0, 0, 1); check("R9 ready after fresh count");

    apply_reset();
    check("R1 reset from power-on");

    for (int i = 0; i < 100; i++) begin step(0, 0, 1); check("R11 off ticks"); end
    step(1, 5'b00011, 0);
    for (int i = 0; i < LOCK - 1; i++) step(0, 0, 1);
    check("R11 not ready after 73");
    step(0, 0, 1); check("R7 ready at 74");

    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [4:0] wd;
      we = ($urandom % 150) == 0;
      wd = 5'($urandom);
      if (($urandom % 2) == 0) wd[1:0] = 2'b11;
      step(we, wd, ($urandom % 3) != 0);
      check("R2 R10 random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule